// File: doc/BRIEF.md
# Two-level selectable 4-bit/8-bit ALU

This block is a purely combinational arithmetic and logic unit. It works on one 8-bit operand bus. Depending on the operation, it reads that bus as two 4-bit unsigned numbers or as a single 8-bit value. A 2-bit group select chooses one of three operation groups: bitwise logic, arithmetic, or magnitude comparison. The fourth group code parks the block with a zero result. A 2-bit operation select then chooses one of four operations inside the chosen group.

Each group is a separate submodule with its own 4-way operation multiplexer, and a group multiplexer combines their outputs. The 8-bit result and a one-bit spill flag go to an external hexadecimal display driver. The group code is echoed on its own output so that indicators can show the active group.

The only operations that can set the spill flag are doubling and halving. In both cases the flag holds the bit that was shifted out: the lost top bit when doubling, and the lost half when halving. Addition and subtraction never overflow the 8-bit bus, because the carry or borrow is placed directly above the 4-bit sum or difference.

Top module: `alu_multimode`

## Requirements
- R1: The low nibble `operand[3:0]` is X and the high nibble `operand[7:4]` is Y. Every two-operand operation uses these nibbles. NOT, doubling and halving use all 8 bits.
- R2: With `grp_sel`=00, `op_sel` 00, 01 and 10 give X AND Y, X OR Y and X XOR Y. The 4-bit result is zero-extended to 8 bits and `spill` is 0.
- R3: With `grp_sel`=00 and `op_sel`=11, `result` is the bitwise inverse of all 8 operand bits and `spill` is 0.
- R4: With `grp_sel`=01 and `op_sel`=00, `result[4:0]` is the carry-out of a 4-stage ripple-carry sum of X+Y concatenated above the sum, with carry-in 0. `result[7:5]` is 0 and `spill` is 0.
- R5: With `grp_sel`=01 and `op_sel`=01, `result[3:0]` is (X−Y) mod 16 and `result[4]` is the final borrow, which is 1 exactly when X<Y. The first borrow-in is 0, `result[7:5]` is 0 and `spill` is 0.
- R6: With `grp_sel`=01 and `op_sel`=10, `result` is the operand shifted left by one with 0 entering bit 0, and `spill` is the original `operand[7]`.
- R7: With `grp_sel`=01 and `op_sel`=11, `result` is the operand shifted right by one with 0 entering bit 7, and `spill` is the original `operand[0]`.
- R8: With `grp_sel`=10, `op_sel` 00, 01 and 10 test X>Y, X<Y and X==Y as unsigned values. `result` is 8'h01 when the test holds and 8'h00 when it does not, and `spill` is 0.
- R9: With `grp_sel`=10 and `op_sel`=11, `result` is the larger of X and Y zero-extended to 8 bits, or X when they are equal. `spill` is 0.
- R10: With `grp_sel`=11, `result` is 8'h00 and `spill` is 0 for every `op_sel` and operand.
- R11: `grp_out` always equals `grp_sel`.
- R12: `spill` can be 1 only when `grp_sel`=01 and `op_sel[1]`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp_sel | input | 2 | Operation group: 00 logic, 01 arithmetic, 10 compare, 11 parked |
| op_sel | input | 2 | Operation within the selected group |
| operand | input | 8 | Operand bus; [3:0]=X, [7:4]=Y |
| result | output | 8 | Selected operation result |
| spill | output | 1 | Bit shifted out by doubling or halving |
| grp_out | output | 2 | Copy of the group select for indicators |

## Verification
The bench builds the block with its default nibble width of 4, which gives an 8-bit operand bus. At that width the full input space is 4 groups × 4 operations × 256 operands = 4096 vectors, so every combination is applied once and compared against a behavioural integer model. This reaches every carry and borrow ripple path, every equal/greater/less boundary, both shifted-out bit values, and the parked group under all operands. Directed vectors are added for the extreme sums, a borrowing subtraction, and the max tie.

// File: rtl/alu_mm_pkg.sv
package alu_mm_pkg;

    typedef enum logic [1:0] {
        GRP_LOGIC = 2'b00,
        GRP_ARITH = 2'b01,
        GRP_CMP   = 2'b10,
        GRP_PARK  = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_INV = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        AOP_ADD = 2'b00,
        AOP_SUB = 2'b01,
        AOP_DBL = 2'b10,
        AOP_HLV = 2'b11
    } aop_e;

    typedef enum logic [1:0] {
        COP_GT  = 2'b00,
        COP_LT  = 2'b01,
        COP_EQ  = 2'b10,
        COP_MAX = 2'b11
    } cop_e;

endpackage

// File: rtl/alu_mm_logic.sv
module alu_mm_logic
    import alu_mm_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BUS_W = 2 * NIB_W
) (
    input  logic [1:0]       op,
    input  logic [BUS_W-1:0] opnd,
    output logic [BUS_W-1:0] res
);
    logic [NIB_W-1:0] x_n, y_n;
    assign x_n = opnd[NIB_W-1:0];
    assign y_n = opnd[BUS_W-1:NIB_W];

    always_comb begin
        unique case (lop_e'(op))
            LOP_AND: res = {{NIB_W{1'b0}}, x_n & y_n};
            LOP_OR:  res = {{NIB_W{1'b0}}, x_n | y_n};
            LOP_XOR: res = {{NIB_W{1'b0}}, x_n ^ y_n};
            default: res = ~opnd;
        endcase
    end

    // Inversion must leave no bit in common with the operand
    always_comb begin
        if (!$isunknown({op, opnd}) && op == 2'b11) begin
            AST_INV_DISJOINT: assert ((res & opnd) == '0 && (res | opnd) == '1); // R3
        end
    end
endmodule

// File: rtl/alu_mm_arith.sv
module alu_mm_arith
    import alu_mm_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BUS_W = 2 * NIB_W,
    localparam int PAD_W = BUS_W - NIB_W - 1
) (
    input  logic [1:0]       op,
    input  logic [BUS_W-1:0] opnd,
    output logic [BUS_W-1:0] res,
    output logic             spill
);
    logic [NIB_W-1:0] x_n, y_n, sum_n, dif_n;
    logic [NIB_W:0]   cy, bw;
    assign x_n = opnd[NIB_W-1:0];
    assign y_n = opnd[BUS_W-1:NIB_W];
    assign cy[0] = 1'b0;
    assign bw[0] = 1'b0;

    for (genvar i = 0; i < NIB_W; i++) begin : g_stage
        // full adder stage
        assign sum_n[i]  = x_n[i] ^ y_n[i] ^ cy[i];
        assign cy[i+1]   = (x_n[i] & y_n[i]) | (cy[i] & (x_n[i] ^ y_n[i]));
        // full subtractor stage
        assign dif_n[i]  = x_n[i] ^ y_n[i] ^ bw[i];
        assign bw[i+1]   = (~x_n[i] & y_n[i]) | (bw[i] & ~(x_n[i] ^ y_n[i]));
    end

    always_comb begin
        unique case (aop_e'(op))
            AOP_ADD: begin res = {{PAD_W{1'b0}}, cy[NIB_W], sum_n}; spill = 1'b0; end
            AOP_SUB: begin res = {{PAD_W{1'b0}}, bw[NIB_W], dif_n}; spill = 1'b0; end
            AOP_DBL: begin res = {opnd[BUS_W-2:0], 1'b0}; spill = opnd[BUS_W-1]; end
            default: begin res = {1'b0, opnd[BUS_W-1:1]}; spill = opnd[0]; end
        endcase
    end

    // Ripple chains cross-checked against integer arithmetic
    always_comb begin
        if (!$isunknown(opnd)) begin
            AST_RIPPLE_SUM: assert ({cy[NIB_W], sum_n} == ({1'b0, x_n} + {1'b0, y_n})); // R4
            AST_RIPPLE_DIF: assert ({bw[NIB_W], dif_n} == ({1'b0, x_n} - {1'b0, y_n})); // R5
        end
    end
endmodule

// File: rtl/alu_mm_cmp.sv
module alu_mm_cmp
    import alu_mm_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BUS_W = 2 * NIB_W
) (
    input  logic [1:0]       op,
    input  logic [BUS_W-1:0] opnd,
    output logic [BUS_W-1:0] res
);
    logic [NIB_W-1:0] x_n, y_n;
    logic             y_wins, term;
    assign x_n = opnd[NIB_W-1:0];
    assign y_n = opnd[BUS_W-1:NIB_W];

    // Sum of products: Y is larger when some bit has Y=1, X=0 and all higher bits agree
    always_comb begin
        y_wins = 1'b0;
        term   = 1'b0;
        for (int i = 0; i < NIB_W; i++) begin
            term = y_n[i] & ~x_n[i];
            for (int j = i + 1; j < NIB_W; j++) begin
                term = term & ~(x_n[j] ^ y_n[j]);
            end
            y_wins = y_wins | term;
        end
    end

    always_comb begin
        unique case (cop_e'(op))
            COP_GT:  res = {{(BUS_W-1){1'b0}}, x_n > y_n};
            COP_LT:  res = {{(BUS_W-1){1'b0}}, x_n < y_n};
            COP_EQ:  res = {{(BUS_W-1){1'b0}}, x_n == y_n};
            default: res = {{NIB_W{1'b0}}, y_wins ? y_n : x_n};
        endcase
    end

    always_comb begin
        if (!$isunknown({op, opnd})) begin
            if (op != 2'b11) begin
                AST_CMP_BOOL: assert (res <= BUS_W'(1)); // R8
            end else begin
                AST_MAX_BOUND: assert (res >= BUS_W'(x_n) && res >= BUS_W'(y_n)); // R9
            end
        end
    end
endmodule

// File: rtl/alu_multimode.sv
module alu_multimode
    import alu_mm_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BUS_W = 2 * NIB_W
) (
    input  logic [1:0]       grp_sel,
    input  logic [1:0]       op_sel,
    input  logic [BUS_W-1:0] operand,
    output logic [BUS_W-1:0] result,
    output logic             spill,
    output logic [1:0]       grp_out
);
    logic [BUS_W-1:0] lg_res, ar_res, cm_res;
    logic             ar_spill;

    alu_mm_logic #(.NIB_W(NIB_W)) u_logic (.op(op_sel), .opnd(operand), .res(lg_res));
    alu_mm_arith #(.NIB_W(NIB_W)) u_arith (.op(op_sel), .opnd(operand), .res(ar_res), .spill(ar_spill));
    alu_mm_cmp   #(.NIB_W(NIB_W)) u_cmp   (.op(op_sel), .opnd(operand), .res(cm_res));

    assign grp_out = grp_sel;

    always_comb begin
        unique case (grp_e'(grp_sel))
            GRP_LOGIC: begin result = lg_res; spill = 1'b0;     end
            GRP_ARITH: begin result = ar_res; spill = ar_spill; end
            GRP_CMP:   begin result = cm_res; spill = 1'b0;     end
            default:   begin result = '0;     spill = 1'b0;     end
        endcase
    end

    always_comb begin
        if (!$isunknown({grp_sel, op_sel, operand})) begin
            if (grp_sel == 2'b11) begin
                AST_PARK_ZERO: assert (result == '0 && !spill); // R10
            end
            if (spill) begin
                AST_SPILL_SHIFT_ONLY: assert (grp_sel == 2'b01 && op_sel[1]); // R12
            end
        end
    end
endmodule

// File: tb/tb_alu_multimode.sv
module tb_alu_multimode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] grp_sel, op_sel, grp_out;
    logic [7:0] operand, result;
    logic       spill;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    alu_multimode dut (.grp_sel(grp_sel), .op_sel(op_sel), .operand(operand),
                       .result(result), .spill(spill), .grp_out(grp_out));

    // Behavioural reference built on integers
    function automatic void model(input int g, input int o, input int v,
                                  output int r, output int f);
        int x, y;
        x = v % 16;
        y = v / 16;
        r = 0;
        f = 0;
        case (g)
            0: case (o)
                   0: r = x & y;
                   1: r = x | y;
                   2: r = x ^ y;
                   default: r = 255 - v;
               endcase
            1: case (o)
                   0: r = x + y;
                   1: r = (x >= y) ? (x - y) : (32 + x - y);
                   2: begin r = (v * 2) % 256; f = v / 128; end
                   default: begin r = v / 2; f = v % 2; end
               endcase
            2: case (o)
                   0: r = (x > y) ? 1 : 0;
                   1: r = (x < y) ? 1 : 0;
                   2: r = (x == y) ? 1 : 0;
                   default: r = (y > x) ? y : x;
               endcase
            default: r = 0;
        endcase
    endfunction

    function automatic string tag_of(input int g, input int o);
        if (g == 0) return (o == 3) ? "R3" : "R2";
        if (g == 1) begin
            case (o)
                0: return "R4";
                1: return "R5";
                2: return "R6";
                default: return "R7";
            endcase
        end
        if (g == 2) return (o == 3) ? "R9" : "R8";
        return "R10";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int g, input int o, input int v, input string tag);
        int er, ef;
        @(negedge clk);
        grp_sel = 2'(g);
        op_sel  = 2'(o);
        operand = 8'(v);
        @(posedge clk);
        #1;
        model(g, o, v, er, ef);
        check(tag, int'(result), er, "result");
        check((g == 1) ? tag : "R12", int'(spill), ef, "spill");
        check("R11", int'(grp_out), g, "grp_out");
    endtask

    initial begin
        grp_sel = 2'b00;
        op_sel  = 2'b00;
        operand = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R2", int'(result), 0, "result after reset");
        check("R12", int'(spill), 0, "spill after reset");

        // R1: X=0xA in low nibble, Y=0x7 in high nibble
        apply(0, 0, 8'h7A, "R1");
        check("R1", int'(result), 8'h02, "AND nibble order");
        apply(2, 0, 8'h7A, "R1");
        check("R1", int'(result), 8'h01, "X>Y nibble order");
        // R4 largest sum
        apply(1, 0, 8'hFF, "R4");
        check("R4", int'(result), 8'h1E, "15+15");
        // R5 borrowing difference 3-5
        apply(1, 1, 8'h53, "R5");
        check("R5", int'(result), 8'h1E, "3-5");
        // R6 / R7 shifted-out bits
        apply(1, 2, 8'h81, "R6");
        check("R6", int'(spill), 1, "double spill");
        apply(1, 3, 8'h03, "R7");
        check("R7", int'(spill), 1, "halve spill");
        // R9 tie and R3 inversion
        apply(2, 3, 8'h99, "R9");
        check("R9", int'(result), 8'h09, "max tie");
        apply(0, 3, 8'h5A, "R3");
        check("R3", int'(result), 8'hA5, "invert");
        // R10 parked group with all-ones operand
        apply(3, 2, 8'hFF, "R10");
        check("R10", int'(result), 0, "parked");

        // Exhaustive sweep
        for (int g = 0; g < 4; g++)
            for (int o = 0; o < 4; o++)
                for (int v = 0; v < 256; v++)
                    apply(g, o, v, tag_of(g, o));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule